// File: doc/BRIEF.md
# Privileged-Mode Exception Entry Controller

This block decides where instruction fetch goes when the processor takes an exception, and where it goes back to afterwards. When a fault, trap or interrupt is signalled it redirects fetch to the privileged base address plus a fixed offset for that kind of event. It also records the restart address and enters privileged mode. Entering privileged mode makes a fixed group of integer registers read from their shadow copies. A return request sends fetch back to the recorded restart address. Privileged mode is left only when bit 0 of that address is clear. A return also re-arms interrupt checking.

All state is held in registers and updates on the rising clock edge. Reset is synchronous and active high. Out of reset the block is already in privileged mode, with the shadow registers selected and fetch pointing at the reset entry. The register file and the pipeline lie outside the block. The pipeline reads `fetch_pc`, `fetch_npc`, `shadow_sel` and the one-cycle flags.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge the block loads `fetch_pc` = `priv_base` + 0x1, `fetch_npc` = `fetch_pc` + 4, `saved_pc` = 0, `priv_mode` = 1, `intr_check_en` = 0, and both pulse flags are 0.
- R2: When an event is taken, `fetch_pc` becomes `priv_base` plus the offset for its code on `fault_code`. The codes and offsets are: 0 none → 0x000, 1 machine check → 0x401, 2 misalignment → 0x301, 3 privileged call → 0x2001, 4 arithmetic → 0x501, 5 interrupt → 0x101. Codes 6 and 7 behave like code 0.
- R3: When an event is taken, `saved_pc` becomes `cur_pc` + 4 for the trap codes 3 and 4. For every other code it becomes `cur_pc`.
- R4: An interrupt (code 5) taken while `priv_mode` is 1 leaves `saved_pc` unchanged.
- R5: Taking an event sets `priv_mode` to 1 and clears `intr_check_en`. `shadow_sel` bit i is 1 exactly when `priv_mode` is 1 and i is in 8..14 or equals 25.
- R6: Taking an event while `priv_mode` is already 1 raises `mode_err` for the one following cycle. An event taken from user mode does not raise it.
- R7: A return accepted in privileged mode loads `fetch_pc` from `saved_pc` and sets `intr_check_en` to 1.
- R8: An accepted return clears `priv_mode` only when bit 0 of `saved_pc` is 0. When that bit is 1 the block stays in privileged mode.
- R9: A return requested while `priv_mode` is 0 raises `unimpl_fault` for one cycle. It changes neither the fetch addresses, `saved_pc`, `priv_mode` nor `intr_check_en`.
- R10: When `fault_valid` and `return_req` are both high, the event is taken and the return is ignored.
- R11: After every update `fetch_npc` equals `fetch_pc` + 4.
- R12: In a cycle with neither `fault_valid` nor `return_req`, all state holds and both pulse flags fall to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_valid | input | 1 | An event is taken this cycle |
| fault_code | input | 3 | Event code (see R2) |
| cur_pc | input | XLEN | PC of the instruction at the event |
| return_req | input | 1 | Return-from-exception request |
| priv_base | input | XLEN | Privileged base address |
| fetch_pc | output | XLEN | Redirected fetch address |
| fetch_npc | output | XLEN | Following fetch address |
| saved_pc | output | XLEN | Saved restart address |
| priv_mode | output | 1 | Privileged-mode flag |
| shadow_sel | output | NREGS | Per-register shadow bank select |
| intr_check_en | output | 1 | Interrupt checking armed |
| mode_err | output | 1 | Entry requested while already privileged (pulse) |
| unimpl_fault | output | 1 | Return attempted from user mode (pulse) |

## Verification
The assertions check on every cycle the cause-and-effect rules that hold whatever the history:
- entry always lands in privileged mode;
- re-entry raises the mode error;
- an interrupt in privileged mode keeps the saved address;
- a return from user mode is refused;
- an accepted return loads the saved address, and leaves privileged mode when bit 0 is clear.

Only the bench's scenarios can show the exact vector offsets for each code, and the plus-four rule for traps against faults. The same goes for the bit-0 privileged return, priority over a simultaneous return, and the reset values. These need expected addresses worked out along a known sequence of events.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_MCHK  = 3'd1,
        EV_ALIGN = 3'd2,
        EV_CALL  = 3'd3,
        EV_ARITH = 3'd4,
        EV_INTR  = 3'd5
    } event_e;

    localparam int OFS_W = 16;
    localparam logic [OFS_W-1:0] OFS_RESET = 16'h0001;
    localparam int INSN_BYTES = 4;

    typedef struct packed {
        logic [OFS_W-1:0] offset;
        logic             is_trap;
        logic             is_intr;
    } vec_info_t;

    function automatic vec_info_t decode_event(input logic [2:0] code);
        vec_info_t v;
        v = '{offset: '0, is_trap: 1'b0, is_intr: 1'b0};
        case (code)
            EV_MCHK:  v.offset = 16'h0401;
            EV_ALIGN: v.offset = 16'h0301;
            EV_CALL:  begin v.offset = 16'h2001; v.is_trap = 1'b1; end
            EV_ARITH: begin v.offset = 16'h0501; v.is_trap = 1'b1; end
            EV_INTR:  begin v.offset = 16'h0101; v.is_intr = 1'b1; end
            default:  v.offset = '0;
        endcase
        return v;
    endfunction

    function automatic logic is_shadowed(input int idx);
        return ((idx >= 8) && (idx <= 14)) || (idx == 25);
    endfunction

endpackage

// File: rtl/exc_vector_sel.sv
`timescale 1ns/1ps
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0]      code,
    input  logic [XLEN-1:0] base,
    output logic [XLEN-1:0] target,
    output logic            is_trap,
    output logic            is_intr
);
    vec_info_t info;

    always_comb begin
        info    = decode_event(code);
        target  = base + {{(XLEN-OFS_W){1'b0}}, info.offset};
        is_trap = info.is_trap;
        is_intr = info.is_intr;
    end
endmodule

// File: rtl/exc_restart_calc.sv
`timescale 1ns/1ps
module exc_restart_calc
    import exc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            take,
    input  logic            is_trap,
    input  logic            is_intr,
    input  logic            in_priv,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] saved_q,
    output logic [XLEN-1:0] saved_d
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        saved_d = saved_q;
        if (take && !(is_intr && in_priv)) begin
            saved_d = is_trap ? (cur_pc + STEP) : cur_pc;
        end
    end
endmodule

// File: rtl/exc_mode_ctrl.sv
`timescale 1ns/1ps
module exc_mode_ctrl
    import exc_pkg::*;
#(
    parameter int NREGS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    input  logic             leave,
    output logic             priv_q,
    output logic             err_q,
    output logic [NREGS-1:0] shadow_sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q <= 1'b1;
            err_q  <= 1'b0;
        end else begin
            err_q <= enter && priv_q;
            if (enter)      priv_q <= 1'b1;
            else if (leave) priv_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_shadow
        if (is_shadowed(g)) begin : g_on
            assign shadow_sel[g] = priv_q;
        end else begin : g_off
            assign shadow_sel[g] = 1'b0;
        end
    end

    assert_entry_sets_mode_R5: assert property (@(posedge clk) disable iff (rst)
        enter |=> priv_q);
    assert_reentry_err_R6: assert property (@(posedge clk) disable iff (rst)
        (enter && priv_q) |=> err_q);
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int NREGS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_valid,
    input  logic [2:0]       fault_code,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             return_req,
    input  logic [XLEN-1:0]  priv_base,
    output logic [XLEN-1:0]  fetch_pc,
    output logic [XLEN-1:0]  fetch_npc,
    output logic [XLEN-1:0]  saved_pc,
    output logic             priv_mode,
    output logic [NREGS-1:0] shadow_sel,
    output logic             intr_check_en,
    output logic             mode_err,
    output logic             unimpl_fault
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] vec_target, saved_next, pc_next;
    logic            ev_trap, ev_intr;
    logic            ret_ok, ret_bad, leave_priv, pc_load;

    exc_vector_sel #(.XLEN(XLEN)) u_vec (
        .code    (fault_code),
        .base    (priv_base),
        .target  (vec_target),
        .is_trap (ev_trap),
        .is_intr (ev_intr)
    );

    exc_restart_calc #(.XLEN(XLEN)) u_restart (
        .take    (fault_valid),
        .is_trap (ev_trap),
        .is_intr (ev_intr),
        .in_priv (priv_mode),
        .cur_pc  (cur_pc),
        .saved_q (saved_pc),
        .saved_d (saved_next)
    );

    always_comb begin
        ret_ok     = return_req && !fault_valid && priv_mode;
        ret_bad    = return_req && !fault_valid && !priv_mode;
        leave_priv = ret_ok && !saved_pc[0];
        pc_load    = fault_valid || ret_ok;
        pc_next    = fault_valid ? vec_target : saved_pc;
    end

    exc_mode_ctrl #(.NREGS(NREGS)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .enter      (fault_valid),
        .leave      (leave_priv),
        .priv_q     (priv_mode),
        .err_q      (mode_err),
        .shadow_sel (shadow_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pc      <= priv_base + {{(XLEN-OFS_W){1'b0}}, OFS_RESET};
            fetch_npc     <= priv_base + {{(XLEN-OFS_W){1'b0}}, OFS_RESET} + STEP;
            saved_pc      <= '0;
            intr_check_en <= 1'b0;
            unimpl_fault  <= 1'b0;
        end else begin
            unimpl_fault <= ret_bad;
            saved_pc     <= saved_next;
            if (pc_load) begin
                fetch_pc  <= pc_next;
                fetch_npc <= pc_next + STEP;
            end
            if (fault_valid)  intr_check_en <= 1'b0;
            else if (ret_ok)  intr_check_en <= 1'b1;
        end
    end

    assert_intr_keeps_saved_R4: assert property (@(posedge clk) disable iff (rst)
        (fault_valid && fault_code == 3'(EV_INTR) && priv_mode) |=> $stable(saved_pc));
    assert_return_target_R7: assert property (@(posedge clk) disable iff (rst)
        (return_req && !fault_valid && priv_mode) |=> (fetch_pc == $past(saved_pc)) && intr_check_en);
    assert_return_leaves_R8: assert property (@(posedge clk) disable iff (rst)
        (return_req && !fault_valid && priv_mode && !saved_pc[0]) |=> !priv_mode);
    assert_user_return_refused_R9: assert property (@(posedge clk) disable iff (rst)
        (return_req && !fault_valid && !priv_mode) |=>
            (unimpl_fault && $stable(fetch_pc) && $stable(priv_mode) && $stable(saved_pc)));
endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
    localparam int XLEN = 64;
    localparam int NREGS = 32;
    localparam int NV = 15;
    localparam logic [63:0] BASE = 64'h1_0000;
    localparam logic [31:0] MASK_ON = 32'h0200_7F00;

    logic clk = 1'b0;
    logic rst, fault_valid, return_req;
    logic [2:0] fault_code;
    logic [XLEN-1:0] cur_pc, priv_base;
    logic [XLEN-1:0] fetch_pc, fetch_npc, saved_pc;
    logic priv_mode, intr_check_en, mode_err, unimpl_fault;
    logic [NREGS-1:0] shadow_sel;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl #(.XLEN(XLEN), .NREGS(NREGS)) i_exc_entry_ctrl (
        .clk(clk), .rst(rst), .fault_valid(fault_valid), .fault_code(fault_code),
        .cur_pc(cur_pc), .return_req(return_req), .priv_base(priv_base),
        .fetch_pc(fetch_pc), .fetch_npc(fetch_npc), .saved_pc(saved_pc),
        .priv_mode(priv_mode), .shadow_sel(shadow_sel), .intr_check_en(intr_check_en),
        .mode_err(mode_err), .unimpl_fault(unimpl_fault)
    );

    // stimulus: valid, return, code, cur_pc ; expected: pc, saved, priv, err, unimpl, intr_en
    localparam logic        V_VAL [NV] = '{0,1,0,1,0,1,1,0,0,1,1,1,0,1,1};
    localparam logic        V_RET [NV] = '{1,0,1,0,1,0,0,1,1,0,0,0,1,1,0};
    localparam logic [2:0]  V_CODE[NV] = '{0,2,0,3,0,4,5,0,0,5,1,2,0,2,0};
    localparam logic [63:0] V_CPC [NV] = '{64'hDEAD0, 64'h1000, 64'hDEAD0, 64'h2000, 64'hDEAD0,
                                           64'h3000, 64'h4000, 64'hDEAD0, 64'hDEAD0, 64'h5000,
                                           64'h6000, 64'h7001, 64'hDEAD0, 64'h8000, 64'h9000};
    localparam logic [63:0] E_PC  [NV] = '{64'h0, 64'h10301, 64'h1000, 64'h12001, 64'h2004,
                                           64'h10501, 64'h10101, 64'h3004, 64'h3004, 64'h10101,
                                           64'h10401, 64'h10301, 64'h7001, 64'h10301, 64'h10000};
    localparam logic [63:0] E_SAV [NV] = '{64'h0, 64'h1000, 64'h1000, 64'h2004, 64'h2004,
                                           64'h3004, 64'h3004, 64'h3004, 64'h3004, 64'h5000,
                                           64'h6000, 64'h7001, 64'h7001, 64'h8000, 64'h9000};
    localparam logic        E_PRV [NV] = '{0,1,0,1,0,1,1,0,0,1,1,1,1,1,1};
    localparam logic        E_ERR [NV] = '{0,0,0,0,0,0,1,0,0,0,1,1,0,1,1};
    localparam logic        E_UNI [NV] = '{0,0,0,0,0,0,0,0,1,0,0,0,0,0,0};
    localparam logic        E_IEN [NV] = '{1,0,1,0,1,0,0,1,1,0,0,0,1,0,0};

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fault_valid = 1'b0; return_req = 1'b0; fault_code = 3'd0; cur_pc = 64'hDEAD0;
    endtask

    task automatic check_reset_state();
        chk("R1", "fetch_pc", fetch_pc, BASE + 64'h1);
        chk("R1", "fetch_npc", fetch_npc, BASE + 64'h5);
        chk("R1", "saved_pc", saved_pc, 64'h0);
        chk("R1", "priv_mode", 64'(priv_mode), 64'h1);
        chk("R1", "shadow_sel", 64'(shadow_sel), 64'(MASK_ON));
        chk("R1", "intr_check_en", 64'(intr_check_en), 64'h0);
        chk("R1", "flags", {62'h0, mode_err, unimpl_fault}, 64'h0);
    endtask

    initial begin
        priv_base = BASE;
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int k = 0; k < NV; k++) begin
            fault_valid = V_VAL[k];
            return_req  = V_RET[k];
            fault_code  = V_CODE[k];
            cur_pc      = V_CPC[k];
            @(negedge clk);
            chk("R2/R7", $sformatf("row %0d fetch_pc", k), fetch_pc, E_PC[k]);
            chk("R11", $sformatf("row %0d fetch_npc", k), fetch_npc, E_PC[k] + 64'h4);
            chk("R3/R4", $sformatf("row %0d saved_pc", k), saved_pc, E_SAV[k]);
            chk("R5/R8", $sformatf("row %0d priv_mode", k), 64'(priv_mode), 64'(E_PRV[k]));
            chk("R5", $sformatf("row %0d shadow_sel", k), 64'(shadow_sel),
                E_PRV[k] ? 64'(MASK_ON) : 64'h0);
            chk("R6", $sformatf("row %0d mode_err", k), 64'(mode_err), 64'(E_ERR[k]));
            chk("R9", $sformatf("row %0d unimpl_fault", k), 64'(unimpl_fault), 64'(E_UNI[k]));
            chk("R7", $sformatf("row %0d intr_check_en", k), 64'(intr_check_en), 64'(E_IEN[k]));
        end

        // R12: idle cycle holds state, pulses fall
        idle_inputs();
        @(negedge clk);
        chk("R12", "idle fetch_pc", fetch_pc, 64'h10000);
        chk("R12", "idle saved_pc", saved_pc, 64'h9000);
        chk("R12", "idle priv_mode", 64'(priv_mode), 64'h1);
        chk("R12", "idle mode_err", 64'(mode_err), 64'h0);

        // R2: unused code 7 behaves like code 0
        fault_valid = 1'b1; fault_code = 3'd7; cur_pc = 64'hA000;
        @(negedge clk);
        chk("R2", "code7 fetch_pc", fetch_pc, BASE);
        chk("R3", "code7 saved_pc", saved_pc, 64'hA000);

        // R1: reset mid-run returns to entry state
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "post-reset hold", fetch_pc, BASE + 64'h1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule